// File: doc/BRIEF.md
# Masked Indexed Vector Atomic Sequencer

This engine carries out one already-decoded vector atomic memory instruction. A single start pulse launches it. It then walks element positions 0 to vl-1 in ascending order. Each active element addresses memory at a scalar base plus that element of an index register. An element is active when masking is off, or when its bit in register 0 is set. Each element's bit sits at a stride of `mask_stride` bits.

The work is done in two passes. The first pass asks a permission port whether each active address may be both read and written. A single refusal ends the operation with a fault and leaves memory and the register store untouched. The second pass performs a read-modify-write for each active element through a one-transaction-at-a-time memory port. The engine can optionally put the old memory value back into the data register. At the end it zeroes the data register's elements from vl up to vlmax-1.

Data elements are `EW` bits wide. Memory accesses are either full width or half width, selected by `half_mem`. The register store, the permission checker and the memory all sit outside the block.

Top module: `vamo_seq`

## Requirements
- R1: When start is accepted with vl = 0, done (without fault) is high in the following cycle, and no probe, memory request or register write occurs.
- R2: With mask_en = 1 (masking active), element i is skipped when bit (i*mask_stride) mod EW of register 0, element (i*mask_stride) div EW, is 0. Its memory location and data element stay unchanged.
- R3: Every active element's address is probed, and acknowledged with probe_ok, before the first memory write. A probe answered with probe_ok = 0 ends the run with done and fault, with no memory write and no register write.
- R4: Element i accesses address base + index_element_i, truncated to ADDR_W bits.
- R5: Let a be the old memory value and b the data element. Op codes 0 swap, 1 add, 2 xor, 3 and and 4 or store b, a+b, a^b, a&b and a|b respectively.
- R6: Op code 5 (signed min) stores b if a >= b, otherwise a. Op code 6 (signed max) stores a if a >= b, otherwise b. Op codes 7 and 8 are the same with an unsigned compare.
- R7: With wd = 1, the old value a replaces the data element after the element's store. With wd = 0, the data element is not written.
- R8: With half_mem = 1, memory accesses use EW/2 bits. b is the low half of the data element, the comparison treats both halves as EW/2-bit numbers, and the returned old value is sign-extended to EW bits.
- R9: After a fault-free run with vl > 0, elements vl to vlmax-1 of the data register read zero.
- R10: Memory transactions follow ascending element order, each a read then a write to the same address. A request holds its address and direction until acknowledged, and only one is outstanding.
- R11: done is a one-cycle pulse, busy is high from acceptance through done, fault is only high together with done, and after reset busy, done, fault and all requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch, accepted when not busy |
| op | input | 4 | Combine code (0..8) |
| half_mem | input | 1 | Half-width memory access |
| mask_en | input | 1 | 1 = honour mask register 0 |
| wd | input | 1 | Return old value to data register |
| data_reg | input | 5 | Data/destination register number |
| index_reg | input | 5 | Index register number |
| base | input | ADDR_W | Scalar base address |
| vl | input | CNT_W | Active length |
| vlmax | input | CNT_W | Register group length |
| mask_stride | input | MSP_W | Bit spacing of mask bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Probe refusal, valid with done |
| vr_rd_sel | output | 5 | Register store read: register |
| vr_rd_elem | output | IDX_W | Register store read: element |
| vr_rd_data | input | EW | Register store read data (same cycle) |
| vr_we | output | 1 | Register store write enable |
| vr_wr_sel | output | 5 | Register store write: register |
| vr_wr_elem | output | IDX_W | Register store write: element |
| vr_wr_data | output | EW | Register store write data |
| probe_req | output | 1 | Permission probe request |
| probe_addr | output | ADDR_W | Probed address |
| probe_ack | input | 1 | Probe answered |
| probe_ok | input | 1 | Load and store both allowed |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_half | output | 1 | Half-width access |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | EW | Write data |
| mem_ack | input | 1 | Transaction complete |
| mem_rdata | input | EW | Read data, valid with mem_ack |

## Verification
Two functions can fall into the same cycle boundary: finishing one element's store and starting the next element's load. When two indices alias, the second load must see the first store's result. The bench provokes this with repeated index values and a memory responder whose acknowledge latency is drawn at random, down to back-to-back. It judges the result by comparing final memory and the order of write addresses against a reference that applies the elements strictly in ascending order. The probe-refusal abort is also checked: memory must be unchanged, and the count of probes seen before the first write is compared with the number of active elements.

// File: rtl/vamo_pkg.sv
package vamo_pkg;
  typedef enum logic [3:0] {
    OP_SWAP = 4'd0, OP_ADD = 4'd1, OP_XOR = 4'd2, OP_AND = 4'd3, OP_OR = 4'd4,
    OP_MIN  = 4'd5, OP_MAX = 4'd6, OP_MINU = 4'd7, OP_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MASK, ST_INDEX, ST_PROBE, ST_OPND,
    ST_LOAD, ST_STORE, ST_RETURN, ST_TAIL, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/vamo_alu.sv
module vamo_alu #(
  parameter int EW = 64
) (
  input  logic [3:0]    op,
  input  logic          half,
  input  logic [EW-1:0] mem_old,
  input  logic [EW-1:0] operand,
  output logic [EW-1:0] store_val,
  output logic [EW-1:0] return_val
);
  import vamo_pkg::*;
  localparam int HW = EW / 2;

  // Widen a half-width value; full-width values pass through.
  function automatic logic [EW-1:0] widen(input logic [EW-1:0] v, input logic nar,
                                          input logic sgn);
    if (!nar) return v;
    return sgn ? {{HW{v[HW-1]}}, v[HW-1:0]} : {{HW{1'b0}}, v[HW-1:0]};
  endfunction

  function automatic logic [EW-1:0] combine(input amo_op_e code, input logic [EW-1:0] a,
                                            input logic [EW-1:0] b);
    logic uns;
    logic a_ge_b;
    uns    = (code == OP_MINU) || (code == OP_MAXU);
    a_ge_b = uns ? (a >= b) : ($signed(a) >= $signed(b));
    case (code)
      OP_ADD:         return a + b;
      OP_XOR:         return a ^ b;
      OP_AND:         return a & b;
      OP_OR:          return a | b;
      OP_MIN, OP_MINU: return a_ge_b ? b : a;
      OP_MAX, OP_MAXU: return a_ge_b ? a : b;
      default:        return b;
    endcase
  endfunction

  amo_op_e      code;
  logic         is_uns;
  logic [EW-1:0] ea, eb, res;

  always_comb begin
    code   = amo_op_e'(op);
    is_uns = (code == OP_MINU) || (code == OP_MAXU);
    ea     = widen(mem_old, half, !is_uns);
    eb     = widen(operand, half, !is_uns);
    res    = combine(code, ea, eb);
    store_val  = half ? {{HW{1'b0}}, res[HW-1:0]} : res;
    return_val = widen(mem_old, half, 1'b1);
  end
endmodule

// File: rtl/vamo_elem_sel.sv
module vamo_elem_sel #(
  parameter int EW     = 64,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int MSP_W  = 8
) (
  input  logic [IDX_W-1:0]  elem_i,
  input  logic [MSP_W-1:0]  stride,
  input  logic [EW-1:0]     mask_word,
  input  logic [ADDR_W-1:0] base,
  input  logic [EW-1:0]     index_word,
  output logic [IDX_W-1:0]  mask_elem,
  output logic              mask_bit,
  output logic [ADDR_W-1:0] elem_addr
);
  localparam int EW_LG = $clog2(EW);
  localparam int POS_W = IDX_W + MSP_W;

  function automatic logic [POS_W-1:0] bit_pos(input logic [IDX_W-1:0] i,
                                               input logic [MSP_W-1:0] s);
    return POS_W'(i) * POS_W'(s);
  endfunction

  logic [POS_W-1:0] pos;
  always_comb begin
    pos       = bit_pos(elem_i, stride);
    mask_elem = IDX_W'(pos >> EW_LG);
    mask_bit  = mask_word[pos[EW_LG-1:0]];
    elem_addr = base + index_word[ADDR_W-1:0];
  end
endmodule

// File: rtl/vamo_seq.sv
module vamo_seq #(
  parameter int EW       = 64,
  parameter int ADDR_W   = 32,
  parameter int MAX_ELEM = 16,
  parameter int MSP_W    = 8,
  localparam int IDX_W   = $clog2(MAX_ELEM),
  localparam int CNT_W   = $clog2(MAX_ELEM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic              half_mem,
  input  logic              mask_en,
  input  logic              wd,
  input  logic [4:0]        data_reg,
  input  logic [4:0]        index_reg,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  vl,
  input  logic [CNT_W-1:0]  vlmax,
  input  logic [MSP_W-1:0]  mask_stride,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [4:0]        vr_rd_sel,
  output logic [IDX_W-1:0]  vr_rd_elem,
  input  logic [EW-1:0]     vr_rd_data,
  output logic              vr_we,
  output logic [4:0]        vr_wr_sel,
  output logic [IDX_W-1:0]  vr_wr_elem,
  output logic [EW-1:0]     vr_wr_data,
  output logic              probe_req,
  output logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_ack,
  input  logic              probe_ok,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_half,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [EW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [EW-1:0]     mem_rdata
);
  import vamo_pkg::*;

  seq_state_e        state;
  logic [3:0]        op_q;
  logic              half_q, mask_q, wd_q, rmw_pass, fault_q;
  logic [4:0]        vd_q, vs_q;
  logic [ADDR_W-1:0] base_q, addr_q;
  logic [CNT_W-1:0]  vl_q, vlmax_q, cnt;
  logic [MSP_W-1:0]  stride_q;
  logic [EW-1:0]     opnd_q, old_q;

  // Named internal events
  logic [CNT_W-1:0]  cnt_nxt;
  logic              last_elem, ev_accept, ev_elem_end, ev_probe_fail, ev_skip;
  logic [IDX_W-1:0]  elem_i, mask_elem;
  logic              mask_bit;
  logic [ADDR_W-1:0] elem_addr;
  logic [EW-1:0]     store_val, return_val;

  assign elem_i    = cnt[IDX_W-1:0];
  assign cnt_nxt   = cnt + CNT_W'(1);
  assign last_elem = (cnt_nxt == vl_q);
  assign ev_accept = start && (state == ST_IDLE);
  assign ev_skip   = (state == ST_MASK) && !(!mask_q || mask_bit);
  assign ev_probe_fail = (state == ST_PROBE) && probe_ack && !probe_ok;
  assign ev_elem_end = ev_skip
                    || ((state == ST_PROBE) && probe_ack && probe_ok)
                    || ((state == ST_STORE) && mem_ack && !wd_q)
                    || (state == ST_RETURN);

  vamo_elem_sel #(.EW(EW), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .MSP_W(MSP_W)) u_sel (
    .elem_i(elem_i), .stride(stride_q), .mask_word(vr_rd_data), .base(base_q),
    .index_word(vr_rd_data), .mask_elem(mask_elem), .mask_bit(mask_bit),
    .elem_addr(elem_addr)
  );

  vamo_alu #(.EW(EW)) u_alu (
    .op(op_q), .half(half_q), .mem_old(old_q), .operand(opnd_q),
    .store_val(store_val), .return_val(return_val)
  );

  // Register store read steering
  always_comb begin
    vr_rd_sel  = vd_q;
    vr_rd_elem = elem_i;
    case (state)
      ST_MASK:  begin vr_rd_sel = 5'd0; vr_rd_elem = mask_elem; end
      ST_INDEX: vr_rd_sel = vs_q;
      default:  vr_rd_sel = vd_q;
    endcase
  end

  // Outputs
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign fault      = done && fault_q;
  assign probe_req  = (state == ST_PROBE);
  assign probe_addr = addr_q;
  assign mem_req    = (state == ST_LOAD) || (state == ST_STORE);
  assign mem_we     = (state == ST_STORE);
  assign mem_half   = half_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = store_val;
  assign vr_we      = (state == ST_RETURN) || (state == ST_TAIL);
  assign vr_wr_sel  = vd_q;
  assign vr_wr_elem = elem_i;
  assign vr_wr_data = (state == ST_RETURN) ? return_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q <= '0; half_q <= 1'b0; mask_q <= 1'b0; wd_q <= 1'b0;
      rmw_pass <= 1'b0; fault_q <= 1'b0;
      vd_q <= '0; vs_q <= '0; base_q <= '0; addr_q <= '0;
      vl_q <= '0; vlmax_q <= '0; cnt <= '0; stride_q <= '0;
      opnd_q <= '0; old_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ev_accept) begin
          op_q <= op; half_q <= half_mem; mask_q <= mask_en; wd_q <= wd;
          vd_q <= data_reg; vs_q <= index_reg; base_q <= base;
          vl_q <= vl; vlmax_q <= vlmax; stride_q <= mask_stride;
          cnt <= '0; rmw_pass <= 1'b0; fault_q <= 1'b0;
          state <= (vl == '0) ? ST_DONE : ST_MASK;
        end
        ST_MASK:  if (!ev_skip) state <= ST_INDEX;
        ST_INDEX: begin
          addr_q <= elem_addr;
          state  <= rmw_pass ? ST_OPND : ST_PROBE;
        end
        ST_PROBE: if (ev_probe_fail) begin
          fault_q <= 1'b1;
          state   <= ST_DONE;
        end
        ST_OPND: begin
          opnd_q <= vr_rd_data;
          state  <= ST_LOAD;
        end
        ST_LOAD: if (mem_ack) begin
          old_q <= mem_rdata;
          state <= ST_STORE;
        end
        ST_STORE: if (mem_ack && wd_q) state <= ST_RETURN;
        ST_TAIL: begin
          cnt <= cnt_nxt;
          if (cnt_nxt == vlmax_q) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: ;
      endcase

      if (ev_elem_end) begin
        if (!last_elem) begin
          cnt   <= cnt_nxt;
          state <= ST_MASK;
        end else if (!rmw_pass) begin
          rmw_pass <= 1'b1;
          cnt      <= '0;
          state    <= ST_MASK;
        end else if (vl_q < vlmax_q) begin
          cnt   <= vl_q;
          state <= ST_TAIL;
        end else begin
          state <= ST_DONE;
        end
      end
    end
  end

  // Assertions
  assert_zero_vl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vl == '0) |=> (done && !fault));

  assert_no_write_in_probe_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |-> !mem_req && !vr_we);

  assert_tail_writes_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_we && vr_wr_elem >= vl_q[IDX_W-1:0] && vl_q < vlmax_q && !$past(mem_req))
      |-> (vr_wr_data == '0));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_read_before_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && $stable(mem_addr)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  assert_probe_mem_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({probe_req, mem_req, vr_we}));
endmodule

// File: tb/vamo_seq_tb.sv
module vamo_seq_tb;
  localparam int EW = 64, ADDR_W = 32, IDX_W = 4, CNT_W = 5, MSP_W = 8;
  localparam logic [4:0] VD = 5'd8, VS = 5'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              start, half_mem, mask_en, wd;
  logic [3:0]        op;
  logic [4:0]        data_reg, index_reg;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  vl, vlmax;
  logic [MSP_W-1:0]  mask_stride;
  logic              busy, done, fault;
  logic [4:0]        vr_rd_sel, vr_wr_sel;
  logic [IDX_W-1:0]  vr_rd_elem, vr_wr_elem;
  logic [EW-1:0]     vr_rd_data, vr_wr_data, mem_wdata, mem_rdata;
  logic              vr_we, probe_req, probe_ack, probe_ok;
  logic [ADDR_W-1:0] probe_addr, mem_addr;
  logic              mem_req, mem_we, mem_half, mem_ack;

  vamo_seq u_dut (.*);

  logic [EW-1:0] vrf [0:31][0:15];
  logic [7:0]    mem [0:255];
  assign vr_rd_data = vrf[vr_rd_sel][vr_rd_elem];

  int n_cmp = 0, n_bad = 0;
  int cycles = 0;
  logic [ADDR_W-1:0] fail_addr;
  int m_wait = 0, p_wait = 0;
  int probes_seen, first_wr_probes, n_wr, n_vrw;
  logic [ADDR_W-1:0] wr_log [0:15];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (vr_we) begin
      vrf[vr_wr_sel][vr_wr_elem] <= vr_wr_data;
      n_vrw <= n_vrw + 1;
    end
  end

  // Memory responder with random latency
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (m_wait == 0) begin
        if (mem_we) begin
          for (int k = 0; k < (mem_half ? 4 : 8); k++)
            mem[8'(mem_addr) + 8'(k)] = mem_wdata[8*k +: 8];
          if (n_wr == 0) first_wr_probes = probes_seen;
          if (n_wr < 16) wr_log[n_wr] = mem_addr;
          n_wr = n_wr + 1;
        end else begin
          logic [63:0] r;
          r = '0;
          for (int k = 0; k < (mem_half ? 4 : 8); k++)
            r[8*k +: 8] = mem[8'(mem_addr) + 8'(k)];
          mem_rdata <= r;
        end
        mem_ack <= 1'b1;
        m_wait = $urandom % 3;
      end else m_wait = m_wait - 1;
    end
  end

  // Probe responder
  always @(posedge clk) begin
    probe_ack <= 1'b0;
    if (probe_req && !probe_ack) begin
      if (p_wait == 0) begin
        probe_ack <= 1'b1;
        probe_ok  <= (probe_addr != fail_addr);
        probes_seen = probes_seen + 1;
        p_wait = $urandom % 2;
      end else p_wait = p_wait - 1;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent reference of the combine step
  function automatic logic [63:0] ref_op(int code, logic nar, logic [63:0] a, logic [63:0] b);
    if (nar) begin
      logic [31:0] x, y, r;
      x = a[31:0]; y = b[31:0];
      case (code)
        0: r = y;       1: r = x + y;   2: r = x ^ y;
        3: r = x & y;   4: r = x | y;
        5: r = ($signed(x) < $signed(y)) ? x : y;
        6: r = ($signed(x) < $signed(y)) ? y : x;
        7: r = (x < y) ? x : y;
        default: r = (x < y) ? y : x;
      endcase
      return {32'b0, r};
    end else begin
      case (code)
        0: return b;      1: return a + b;   2: return a ^ b;
        3: return a & b;  4: return a | b;
        5: return ($signed(a) < $signed(b)) ? a : b;
        6: return ($signed(a) < $signed(b)) ? b : a;
        7: return (a < b) ? a : b;
        default: return (a < b) ? b : a;
      endcase
    end
  endfunction

  logic [7:0]  exp_mem [0:255];
  logic [63:0] exp_vd [0:15];
  logic [ADDR_W-1:0] exp_wr [0:15];
  int exp_nwr, exp_active;
  logic exp_fault;

  task automatic build_expected(int code, logic nar, logic me, logic w, int n, int nmax,
                                int stride, logic [ADDR_W-1:0] bs);
    logic act [0:15];
    logic [ADDR_W-1:0] ad [0:15];
    for (int k = 0; k < 256; k++) exp_mem[k] = mem[k];
    for (int k = 0; k < 16; k++) exp_vd[k] = vrf[VD][k];
    exp_fault = 1'b0; exp_active = 0; exp_nwr = 0;
    for (int i = 0; i < n; i++) begin
      int p;
      p = i * stride;
      act[i] = !me || vrf[0][p / 64][p % 64];
      ad[i]  = bs + vrf[VS][i][ADDR_W-1:0];
      if (act[i]) begin
        exp_active++;
        if (ad[i] == fail_addr) exp_fault = 1'b1;
      end
    end
    if (exp_fault) return;
    for (int i = 0; i < n; i++) if (act[i]) begin
      logic [63:0] a, r;
      a = '0;
      for (int k = 0; k < (nar ? 4 : 8); k++) a[8*k +: 8] = exp_mem[8'(ad[i]) + 8'(k)];
      r = ref_op(code, nar, a, exp_vd[i]);
      for (int k = 0; k < (nar ? 4 : 8); k++) exp_mem[8'(ad[i]) + 8'(k)] = r[8*k +: 8];
      if (w) exp_vd[i] = nar ? {{32{a[31]}}, a[31:0]} : a;
      exp_wr[exp_nwr] = ad[i];
      exp_nwr++;
    end
    if (n > 0) for (int i = n; i < nmax; i++) exp_vd[i] = '0;
  endtask

  task automatic run_case(string req, int code, logic nar, logic me, logic w, int n,
                          int nmax, int stride, logic [ADDR_W-1:0] bs);
    int waited, diff;
    logic got_fault;
    build_expected(code, nar, me, w, n, nmax, stride, bs);
    probes_seen = 0; first_wr_probes = -1; n_wr = 0; n_vrw = 0;
    @(negedge clk);
    op = 4'(code); half_mem = nar; mask_en = me; wd = w; base = bs;
    vl = CNT_W'(n); vlmax = CNT_W'(nmax); mask_stride = MSP_W'(stride);
    data_reg = VD; index_reg = VS; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 1;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    got_fault = fault;
    chk(req, "completion seen", 64'(done), 64'd1);
    chk(req, "fault flag", 64'(got_fault), 64'(exp_fault));
    @(negedge clk);
    chk("R11", "done one cycle", {62'd0, done, busy}, 64'd0);
    diff = 0;
    for (int k = 0; k < 256; k++) if (mem[k] !== exp_mem[k]) diff++;
    chk(req, "memory bytes differing", 64'(diff), 64'd0);
    diff = 0;
    for (int k = 0; k < 16; k++) if (vrf[VD][k] !== exp_vd[k]) diff++;
    chk(req, "data elements differing", 64'(diff), 64'd0);
    chk("R10", "write count", 64'(n_wr), 64'(exp_nwr));
    diff = 0;
    for (int k = 0; k < exp_nwr && k < n_wr; k++) if (wr_log[k] !== exp_wr[k]) diff++;
    chk("R10", "write order mismatches", 64'(diff), 64'd0);
    if (exp_nwr > 0) chk("R3", "probes before first write", 64'(first_wr_probes), 64'(exp_active));
    if (n == 0) begin
      chk("R1", "cycles to done", 64'(waited), 64'd1);
      chk("R1", "register writes", 64'(n_vrw), 64'd0);
    end
  endtask

  task automatic fill_regs(logic nar, int ibound);
    for (int k = 0; k < 16; k++) begin
      vrf[0][k]  = {$urandom, $urandom};
      vrf[VS][k] = 64'(($urandom % ibound) * (nar ? 4 : 8));
      vrf[VD][k] = {$urandom, $urandom};
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0a70));
    start = 0; op = 0; half_mem = 0; mask_en = 0; wd = 0; data_reg = 0; index_reg = 0;
    base = 0; vl = 0; vlmax = 0; mask_stride = 1; fail_addr = 32'hFFFF_FFFF;
    mem_rdata = '0; probe_ok = 1'b0;
    for (int r = 0; r < 32; r++) for (int k = 0; k < 16; k++) vrf[r][k] = '0;
    for (int k = 0; k < 256; k++) mem[k] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk("R11", "reset outputs", {59'd0, busy, done, fault, mem_req, probe_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty length
    fill_regs(1'b0, 16);
    run_case("R1", 1, 1'b0, 1'b0, 1'b1, 0, 8, 1, 32'd0);
    // R4 R5 R6 R7 R9: every code, full width, with return and tail
    for (int c = 0; c < 9; c++) begin
      fill_regs(1'b0, 16);
      vrf[VS][1] = vrf[VS][0];  // aliasing index: store then reload same address
      run_case(c < 5 ? "R5" : "R6", c, 1'b0, 1'b0, 1'b1, 5, 9, 1, 32'd16);
    end
    // R8: half width with negative values, every code
    for (int c = 0; c < 9; c++) begin
      fill_regs(1'b1, 16);
      vrf[VD][2] = 64'h0123_4567_8000_0001;
      run_case("R8", c, 1'b1, 1'b0, 1'b1, 6, 6, 1, 32'd8);
    end
    // R7: no return
    fill_regs(1'b0, 16);
    run_case("R7", 1, 1'b0, 1'b0, 1'b0, 7, 12, 1, 32'd0);
    // R2: masking with several strides
    fill_regs(1'b0, 16);
    run_case("R2", 6, 1'b0, 1'b1, 1'b1, 16, 16, 1, 32'd0);
    fill_regs(1'b0, 16);
    run_case("R2", 2, 1'b0, 1'b1, 1'b1, 12, 16, 8, 32'd8);
    fill_regs(1'b0, 16);
    run_case("R2", 7, 1'b1, 1'b1, 1'b1, 15, 15, 64, 32'd4);
    // R3: probe refusal on last element
    fill_regs(1'b0, 16);
    fail_addr = 32'd16 + vrf[VS][5][31:0];
    run_case("R3", 1, 1'b0, 1'b0, 1'b1, 6, 10, 1, 32'd16);
    fail_addr = 32'hFFFF_FFFF;
    // R9: full length with tail reaching the last element
    fill_regs(1'b0, 16);
    run_case("R9", 4, 1'b0, 1'b0, 1'b0, 1, 16, 1, 32'd0);
    // R4 R10: random mix, repeated indices from a small range
    for (int t = 0; t < 40; t++) begin
      logic nar;
      int nmax, n, strides [6];
      strides = '{1, 2, 4, 8, 16, 64};
      nar  = 1'($urandom);
      nmax = 1 + $urandom % 16;
      n    = $urandom % (nmax + 1);
      fill_regs(nar, (t % 2 == 0) ? 4 : 16);
      if ($urandom % 5 == 0 && n > 0)
        fail_addr = 32'(8 * (t % 8)) + vrf[VS][$urandom % n][31:0];
      else fail_addr = 32'hFFFF_FFFF;
      run_case("R4", $urandom % 9, nar, 1'($urandom), 1'($urandom), n, nmax,
               strides[$urandom % 6], 32'(8 * (t % 8)));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // Watchdog
  always @(posedge clk) if (cycles > 150000) begin
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog actual=%0d expected<150000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule